// File: doc/BRIEF.md
# Boundary-Scan Cell Chain

This block is a row of boundary-scan cells that sits between a chip core and its pads. Each cell has two flip-flops. The first one either captures the value present on its parallel input or takes the serial bit from the cell before it. The second one holds a value that can be driven onto the cell's parallel output. A chip-wide drive-select line picks, for every cell at once, what reaches the parallel output: the parallel input passed straight through, or the held value. Because the driven value sits in its own flip-flop, the outputs do not move while a new pattern is being shifted along the chain.

A test controller drives the block through a few control signals. It raises `dr_clk_en` for the cycles of a data-register capture or shift, with `shift_sel` low to capture and high to shift. It raises `update_en` for one cycle to transfer the shifted pattern into the hold stage, and it sets `mode_drive` high when the pins are to be driven from the hold stage. With `mode_drive` low the pins pass through while patterns are sampled and preloaded. With `mode_drive` high the held pattern drives the pins, and a later capture samples what the pins then carry.

Cell 0 receives `scan_in`. Cell i feeds cell i+1, and `scan_out` is the first-stage value of cell N-1. Both stages of every cell clear to 0 on reset, so a switch to drive mode made after reset puts known zeros on the pins.

Top module: `bscan_chain`

## Requirements
- R1: While `rst_n` is low, and right after it is released, every first stage and every hold stage is 0. This shows as `scan_out` = 0 and, with `mode_drive` = 1, as `par_out` = all zeros.
- R2: On a clock edge with `dr_clk_en` = 1 and `shift_sel` = 0, the first stage of cell i loads `par_in[i]` for every i.
- R3: On a clock edge with `dr_clk_en` = 1 and `shift_sel` = 1, the first stage of cell 0 loads `scan_in` and cell i (i ≥ 1) loads the old first-stage value of cell i-1. `scan_out` always shows the first stage of cell N-1. To load pattern p, send p[N-1] first and p[0] last.
- R4: On a clock edge with `update_en` = 1, every hold stage copies the first-stage value of its cell as it was before that edge. A capture or shift on the same edge does not change what the hold stage receives.
- R5: While `mode_drive` = 0, `par_out` equals `par_in` in the same cycle, whatever the hold stages contain.
- R6: While `mode_drive` = 1, `par_out[i]` equals the hold stage of cell i.
- R7: While `mode_drive` = 1 and `update_en` = 0, `par_out` keeps its value across shift and capture edges.
- R8: On an edge with `dr_clk_en` = 0, no first stage changes, whatever `shift_sel`, `scan_in` and `par_in` do.
- R9: In a sample-then-drive sequence (shift pattern in, update, set `mode_drive`), the pins carry the shifted pattern. A following capture then returns the driven pattern on `scan_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock; all flip-flops use its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of both stages |
| dr_clk_en | input | 1 | Enables the first stage for capture or shift |
| shift_sel | input | 1 | 0 selects parallel capture, 1 selects serial shift |
| update_en | input | 1 | Copies first stages into hold stages |
| mode_drive | input | 1 | 0 passes pins through, 1 drives pins from hold stages |
| par_in | input | N | Parallel data from the pads or core, one bit per cell |
| scan_in | input | 1 | Serial input to cell 0 |
| par_out | output | N | Parallel data toward the pads or core, one bit per cell |
| scan_out | output | 1 | Serial output taken from cell N-1 |

## Verification
The properties assume that the controller changes `mode_drive` only between operations, so a stability check over two cycles applies only when drive mode is held across both. They also assume that the first clock after reset sees released controls. The stimulus keeps to these assumptions: it changes controls only one time unit after a rising edge, keeps `mode_drive` fixed through each shift or capture sequence, and asserts `update_en` only for single cycles. With a four-cell chain, the bench runs every 4-bit pattern through capture, shift-out, preload, update, drive and pass-through.

// File: rtl/bsr_pkg.sv
package bsr_pkg;

    // Source feeding the first (capture/shift) stage of a cell
    typedef enum logic {
        SRC_PARALLEL = 1'b0,
        SRC_SERIAL   = 1'b1
    } cap_src_e;

    // Source feeding the parallel output of a cell
    typedef enum logic {
        OUT_PASS  = 1'b0,
        OUT_DRIVE = 1'b1
    } out_sel_e;

endpackage

// File: rtl/bsr_out_mux.sv
module bsr_out_mux
    import bsr_pkg::*;
(
    input  out_sel_e sel,
    input  logic     pin_val,
    input  logic     held_val,
    output logic     out_val
);

    always_comb begin
        unique case (sel)
            OUT_PASS:  out_val = pin_val;
            OUT_DRIVE: out_val = held_val;
            default:   out_val = pin_val;
        endcase
    end

endmodule

// File: rtl/bsr_cell.sv
module bsr_cell
    import bsr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cap_en,
    input  logic shift,
    input  logic upd_en,
    input  logic drive,
    input  logic pin_in,
    input  logic ser_in,
    output logic pin_out,
    output logic ser_out
);

    cap_src_e cap_src;
    out_sel_e out_sel;
    logic     cap_d;
    logic     cap_q;
    logic     hold_q;

    always_comb begin
        cap_src = shift ? SRC_SERIAL : SRC_PARALLEL;
        out_sel = drive ? OUT_DRIVE : OUT_PASS;
    end

    always_comb begin
        unique case (cap_src)
            SRC_PARALLEL: cap_d = pin_in;
            SRC_SERIAL:   cap_d = ser_in;
            default:      cap_d = pin_in;
        endcase
    end

    // First stage: capture or shift
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q <= 1'b0;
        end else if (cap_en) begin
            cap_q <= cap_d;
        end
    end

    // Hold stage: value to drive
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= 1'b0;
        end else if (upd_en) begin
            hold_q <= cap_q;
        end
    end

    bsr_out_mux u_mux (
        .sel      (out_sel),
        .pin_val  (pin_in),
        .held_val (hold_q),
        .out_val  (pin_out)
    );

    assign ser_out = cap_q;

endmodule

// File: rtl/bscan_chain.sv
module bscan_chain #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         dr_clk_en,
    input  logic         shift_sel,
    input  logic         update_en,
    input  logic         mode_drive,
    input  logic [N-1:0] par_in,
    input  logic         scan_in,
    output logic [N-1:0] par_out,
    output logic         scan_out
);

    localparam int LINKS = N + 1;

    logic [LINKS-1:0] ser_link;

    assign ser_link[0] = scan_in;

    for (genvar i = 0; i < N; i++) begin : g_cell
        bsr_cell u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .cap_en  (dr_clk_en),
            .shift   (shift_sel),
            .upd_en  (update_en),
            .drive   (mode_drive),
            .pin_in  (par_in[i]),
            .ser_in  (ser_link[i]),
            .pin_out (par_out[i]),
            .ser_out (ser_link[i+1])
        );
    end

    assign scan_out = ser_link[LINKS-1];

endmodule

// File: rtl/bscan_chain_chk.sv
module bscan_chain_chk #(
    parameter int N = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         dr_clk_en,
    input logic         shift_sel,
    input logic         update_en,
    input logic         mode_drive,
    input logic [N-1:0] par_in,
    input logic         scan_in,
    input logic [N-1:0] par_out,
    input logic         scan_out,
    input logic [N-1:0] cap_q
);

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (scan_out == 1'b0));

    // R2
    capture_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dr_clk_en && !shift_sel) |=> (cap_q == $past(par_in)));

    // R3
    shift_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dr_clk_en && shift_sel) |=> (cap_q[0] == $past(scan_in)));

    // R5
    pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_drive |-> (par_out == par_in));

    // R4
    update_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (update_en && mode_drive) ##1 mode_drive |-> (par_out == $past(cap_q)));

    // R7
    drive_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!update_en && mode_drive) ##1 mode_drive |-> $stable(par_out));

    // R8
    hold_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dr_clk_en |=> $stable(cap_q));

endmodule

bind bscan_chain bscan_chain_chk #(.N(N)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .dr_clk_en  (dr_clk_en),
    .shift_sel  (shift_sel),
    .update_en  (update_en),
    .mode_drive (mode_drive),
    .par_in     (par_in),
    .scan_in    (scan_in),
    .par_out    (par_out),
    .scan_out   (scan_out),
    .cap_q      (ser_link[N:1])
);

// File: tb/bscan_chain_test.sv
module bscan_chain_test;

    localparam int CLK_PERIOD = 10;
    localparam int N = 4;
    localparam int PATS = 1 << N;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         dr_clk_en = 1'b0;
    logic         shift_sel = 1'b0;
    logic         update_en = 1'b0;
    logic         mode_drive = 1'b0;
    logic [N-1:0] par_in = '0;
    logic         scan_in = 1'b0;
    logic [N-1:0] par_out;
    logic         scan_out;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    bscan_chain #(.N(N)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .dr_clk_en  (dr_clk_en),
        .shift_sel  (shift_sel),
        .update_en  (update_en),
        .mode_drive (mode_drive),
        .par_in     (par_in),
        .scan_in    (scan_in),
        .par_out    (par_out),
        .scan_out   (scan_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    // Advance one edge; controls change 1 time unit after the edge
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic idle_ctl();
        dr_clk_en = 1'b0;
        shift_sel = 1'b0;
        update_en = 1'b0;
    endtask

    // Shift pattern p in, p[N-1] first
    task automatic shift_in(input logic [N-1:0] p);
        for (int k = N - 1; k >= 0; k--) begin
            dr_clk_en = 1'b1;
            shift_sel = 1'b1;
            scan_in = p[k];
            tick();
        end
        idle_ctl();
    endtask

    task automatic capture();
        dr_clk_en = 1'b1;
        shift_sel = 1'b0;
        tick();
        idle_ctl();
    endtask

    // Read the chain out, checking scan_out bit by bit
    task automatic shift_out_check(input string req, input logic [N-1:0] exp);
        logic [N-1:0] got;
        got = '0;
        for (int k = N - 1; k >= 0; k--) begin
            got[k] = scan_out;
            dr_clk_en = 1'b1;
            shift_sel = 1'b1;
            scan_in = 1'b0;
            tick();
        end
        idle_ctl();
        check(req, got, exp);
    endtask

    task automatic update();
        update_en = 1'b1;
        tick();
        update_en = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [N-1:0] q;
        mode_drive = 1'b1;
        #3;
        // R1: cleared state during reset
        check("R1 par_out in reset", par_out, '0);
        check("R1 scan_out in reset", {{(N-1){1'b0}}, scan_out}, '0);
        tick();
        tick();
        rst_n = 1'b1;
        tick();
        check("R1 par_out after reset", par_out, '0);
        check("R1 scan_out after reset", {{(N-1){1'b0}}, scan_out}, '0);
        mode_drive = 1'b0;

        for (int p = 0; p < PATS; p++) begin
            // R5: pass-through for every pattern
            par_in = N'(p);
            #1;
            check("R5 pass-through", par_out, N'(p));
            // R2: capture then read out over scan_out
            capture();
            par_in = ~N'(p);
            shift_out_check("R2 capture", N'(p));
        end

        for (int p = 0; p < PATS; p++) begin
            // R3: shift in, first-stage ordering observed on readback
            mode_drive = 1'b0;
            shift_in(N'(p));
            check("R3 scan_out after load", {{(N-1){1'b0}}, scan_out}, {{(N-1){1'b0}}, N'(p) >> (N-1)});
            // R4: update; R5: pins ignore hold stage in pass mode
            update();
            par_in = N'(p) ^ 4'b1010;
            #1;
            check("R5 ignores hold", par_out, N'(p) ^ 4'b1010);
            // R6: drive mode shows hold stage
            mode_drive = 1'b1;
            #1;
            check("R6 drive", par_out, N'(p));
            // R7: shifting other data leaves pins still
            shift_in(~N'(p));
            check("R7 stable during shift", par_out, N'(p));
            capture();
            check("R7 stable during capture", par_out, N'(p));
            // R9: capture in drive mode samples what the pins carry
            par_in = par_out;
            capture();
            shift_out_check("R9 drive sample", N'(p));
            mode_drive = 1'b0;
        end

        // R8: first stages ignore all inputs while disabled
        for (int p = 0; p < PATS; p++) begin
            par_in = N'(p);
            capture();
            for (int c = 0; c < 4; c++) begin
                dr_clk_en = 1'b0;
                shift_sel = c[0];
                scan_in = c[1];
                par_in = N'(c * 5);
                tick();
            end
            shift_out_check("R8 hold", N'(p));
        end

        // R4: update on same edge as shift copies the old first stage
        shift_in(4'b0110);
        dr_clk_en = 1'b1;
        shift_sel = 1'b1;
        scan_in = 1'b1;
        update_en = 1'b1;
        tick();
        idle_ctl();
        mode_drive = 1'b1;
        #1;
        check("R4 same-edge update", par_out, 4'b0110);
        q = 4'b1101;
        shift_out_check("R3 shifted after same edge", q);
        mode_drive = 1'b0;

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule